// File: doc/BRIEF.md
# Two-Layer Stub Correlator

This block pairs hits between the two sensor layers of a stacked strip module during each bunch crossing. It receives two maps of cluster centres, one for the lower layer and one for the upper layer, given in half-strip units. Every set bit in the lower map is a seed. For each seed, the block looks for a set bit in the upper map. The search window is centred on the seed position plus a programmable signed offset and spans a programmable half-width on either side. A seed with a partner in the window forms a stub. The stub carries the seed address and a signed bend, which is the distance of the chosen upper cluster from the window centre.

Every crossing, the block reports the following:
- a stub-found flag;
- an any-hit flag covering both maps;
- up to three stubs, each with a valid bit;
- an overflow flag, set when more seeds matched than can be reported.

All outputs are registered. Narrowing the window raises the momentum cut. The offset compensates for the geometric shift of the module position.

Top module: `stub_correlator`

## Requirements
- R1: During and after a synchronous active-low reset, with no new crossing yet registered, every output is 0.
- R2: A lower-map bit at position i forms a stub exactly when some upper-map bit at position i + offset + b is set with |b| <= win_half. A seed with no upper bit in that range forms no stub.
- R3: The stub bend is b = upper position - (i + offset), as 5-bit two's complement (for example, -5 is 5'b11011). Its magnitude is never larger than win_half.
- R4: The signed 5-bit offset input shifts the window centre. The same seed and upper cluster pair give a bend that differs by the change in offset.
- R5: When several upper clusters lie in a seed's window, the one with the smallest |b| is used. On a tie between +b and -b, the negative bend is chosen.
- R6: stub_flag is 1 for a crossing exactly when at least one seed formed a stub.
- R7: or_flag is 1 when any bit of either map is set, whether or not a stub was formed.
- R8: Up to three stubs are reported in slots 0, 1 and 2, in ascending seed address. Valid bits fill from slot 0 upward with no gaps. When more seeds match, the three lowest addresses are the ones kept.
- R9: overflow is 1 exactly when more than three seeds formed stubs in a crossing.
- R10: Outputs reflect the inputs present at a rising clock edge and appear after that edge. They are unchanged before it.
- R11: Upper positions outside 0..255 never match. The window does not wrap around the ends of the map.
- R12: win_half = 0 accepts only an upper cluster at exactly i + offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lower_map | input | 256 | Lower-layer cluster centres, bit = half-strip position |
| upper_map | input | 256 | Upper-layer cluster centres |
| win_half | input | 4 | Window half-width, 0..15 |
| offset | input | 5 | Signed window-centre shift |
| stub_flag | output | 1 | At least one stub this crossing |
| or_flag | output | 1 | Any bit set in either map |
| stub_valid | output | 3 | Per-slot stub valid |
| stub_addr | output | 3x8 | Per-slot seed address |
| stub_bend | output | 3x5 | Per-slot signed bend |
| overflow | output | 1 | More than three stubs found |

## Verification
Each main-function pattern separates a different failure mode:
- A single seed with an upper hit just inside and then just outside the window shows whether the window bound is inclusive.
- A negative offset combined with a zero window shows whether the centre shift is applied with its sign.
- Two candidates at unequal distances, and then at equal distances of opposite sign, show the nearest-first rule and the tie rule.
- Four simultaneous coincidences show the ascending-address slot order and overflow.
- Windows that reach past either end of the map show that the search does not wrap.

// File: rtl/stubcor_pkg.sv
// Package: shared default dimensions of the stub correlator.
// Assumes positions are in half-strip units and bends fit in BEND_W bits.
package stubcor_pkg;
    localparam int DEF_N_POS    = 256;
    localparam int DEF_ADDR_W   = 8;
    localparam int DEF_BEND_W   = 5;
    localparam int DEF_WIN_W    = 4;
    localparam int DEF_OFFS_W   = 5;
    localparam int DEF_MAX_BEND = 15;
    localparam int DEF_N_STUB   = 3;
endpackage

// File: rtl/stubcor_seed_match.sv
// Module: per-seed window search.
// For every lower position, this module scans upper positions in order of growing distance from
// seed + offset. Negative distance is tried before positive. The first set bit within win_half gives
// the match and its bend. Positions that fall off the map are skipped.
// Assumes MAX_BEND < 2**(BEND_W-1) and the win_half range <= MAX_BEND.
module stubcor_seed_match #(
    parameter int N_POS    = stubcor_pkg::DEF_N_POS,
    parameter int BEND_W   = stubcor_pkg::DEF_BEND_W,
    parameter int WIN_W    = stubcor_pkg::DEF_WIN_W,
    parameter int OFFS_W   = stubcor_pkg::DEF_OFFS_W,
    parameter int MAX_BEND = stubcor_pkg::DEF_MAX_BEND
) (
    input  logic [N_POS-1:0]             lower_map,
    input  logic [N_POS-1:0]             upper_map,
    input  logic [WIN_W-1:0]             win_half,
    input  logic [OFFS_W-1:0]            offset,
    output logic [N_POS-1:0]             match,
    output logic [N_POS-1:0][BEND_W-1:0] bend
);
    localparam int IDX_W = $clog2(N_POS);

    for (genvar g = 0; g < N_POS; g++) begin : g_seed
        // Nearest-first search of the upper map around this seed
        always_comb begin
            int idx;
            int d;
            logic hit;
            hit = 1'b0;
            bend[g] = '0;
            for (int k = 0; k <= MAX_BEND; k++) begin
                for (int s = 0; s < 2; s++) begin
                    d = (s == 0) ? -k : k;
                    idx = g + int'($signed(offset)) + d;
                    if (!hit && lower_map[g] && k <= int'(win_half) &&
                        idx >= 0 && idx < N_POS && upper_map[idx[IDX_W-1:0]]) begin
                        hit = 1'b1;
                        bend[g] = d[BEND_W-1:0];
                    end
                end
            end
            match[g] = hit;
        end
    end
endmodule

// File: rtl/stubcor_pick.sv
// Module: stub slot selection.
// Packs the lowest-address matching seeds into N_STUB slots in ascending order and flags the
// case where more seeds matched than there are slots.
// Assumes addresses are the seed positions themselves.
module stubcor_pick #(
    parameter int N_POS  = stubcor_pkg::DEF_N_POS,
    parameter int ADDR_W = stubcor_pkg::DEF_ADDR_W,
    parameter int BEND_W = stubcor_pkg::DEF_BEND_W,
    parameter int N_STUB = stubcor_pkg::DEF_N_STUB
) (
    input  logic [N_POS-1:0]              match,
    input  logic [N_POS-1:0][BEND_W-1:0]  bend,
    output logic [N_STUB-1:0]             sel_valid,
    output logic [N_STUB-1:0][ADDR_W-1:0] sel_addr,
    output logic [N_STUB-1:0][BEND_W-1:0] sel_bend,
    output logic                          sel_ovf
);
    // Ascending scan filling free slots, counting every match for overflow
    always_comb begin
        int cnt;
        cnt = 0;
        sel_valid = '0;
        sel_addr  = '0;
        sel_bend  = '0;
        for (int i = 0; i < N_POS; i++) begin
            if (match[i]) begin
                for (int s = 0; s < N_STUB; s++) begin
                    if (s == cnt) begin
                        sel_valid[s] = 1'b1;
                        sel_addr[s]  = i[ADDR_W-1:0];
                        sel_bend[s]  = bend[i];
                    end
                end
                cnt = cnt + 1;
            end
        end
        sel_ovf = (cnt > N_STUB);
    end
endmodule

// File: rtl/stub_correlator.sv
// Module: two-layer stub correlator top.
// Combines the per-seed window search and the slot selection, then registers all per-crossing
// results. Outputs reflect the maps present at the previous rising edge.
// Assumes a synchronous active-low reset and static or per-crossing window settings.
module stub_correlator #(
    parameter int N_POS    = stubcor_pkg::DEF_N_POS,
    parameter int ADDR_W   = stubcor_pkg::DEF_ADDR_W,
    parameter int BEND_W   = stubcor_pkg::DEF_BEND_W,
    parameter int WIN_W    = stubcor_pkg::DEF_WIN_W,
    parameter int OFFS_W   = stubcor_pkg::DEF_OFFS_W,
    parameter int MAX_BEND = stubcor_pkg::DEF_MAX_BEND,
    parameter int N_STUB   = stubcor_pkg::DEF_N_STUB
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_POS-1:0]              lower_map,
    input  logic [N_POS-1:0]              upper_map,
    input  logic [WIN_W-1:0]              win_half,
    input  logic [OFFS_W-1:0]             offset,
    output logic                          stub_flag,
    output logic                          or_flag,
    output logic [N_STUB-1:0]             stub_valid,
    output logic [N_STUB-1:0][ADDR_W-1:0] stub_addr,
    output logic [N_STUB-1:0][BEND_W-1:0] stub_bend,
    output logic                          overflow
);
    logic [N_POS-1:0]              match;
    logic [N_POS-1:0][BEND_W-1:0]  bend;
    logic [N_STUB-1:0]             sel_valid;
    logic [N_STUB-1:0][ADDR_W-1:0] sel_addr;
    logic [N_STUB-1:0][BEND_W-1:0] sel_bend;
    logic                          sel_ovf;

    stubcor_seed_match #(
        .N_POS(N_POS), .BEND_W(BEND_W), .WIN_W(WIN_W),
        .OFFS_W(OFFS_W), .MAX_BEND(MAX_BEND)
    ) u_match (
        .lower_map(lower_map), .upper_map(upper_map),
        .win_half(win_half), .offset(offset),
        .match(match), .bend(bend)
    );

    stubcor_pick #(
        .N_POS(N_POS), .ADDR_W(ADDR_W), .BEND_W(BEND_W), .N_STUB(N_STUB)
    ) u_pick (
        .match(match), .bend(bend),
        .sel_valid(sel_valid), .sel_addr(sel_addr),
        .sel_bend(sel_bend), .sel_ovf(sel_ovf)
    );

    // Register the per-crossing results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stub_flag  <= 1'b0;
            or_flag    <= 1'b0;
            stub_valid <= '0;
            stub_addr  <= '0;
            stub_bend  <= '0;
            overflow   <= 1'b0;
        end else begin
            stub_flag  <= |match;
            or_flag    <= |(lower_map | upper_map);
            stub_valid <= sel_valid;
            stub_addr  <= sel_addr;
            stub_bend  <= sel_bend;
            overflow   <= sel_ovf;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (stub_valid == '0 && !stub_flag && !overflow)); // R1
    AST_FLAG_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n) stub_flag == stub_valid[0]); // R6
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n) overflow |-> (&stub_valid)); // R9
    AST_OR_COVERS_STUB: assert property (@(posedge clk) disable iff (!rst_n) stub_flag |-> or_flag); // R7
    AST_BEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        stub_valid[0] |-> ($signed(stub_bend[0]) <= $signed({1'b0, $past(win_half)}) &&
                           $signed(stub_bend[0]) >= -$signed({1'b0, $past(win_half)}))); // R3

    for (genvar s = 1; s < N_STUB; s++) begin : g_slot_chk
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            stub_valid[s] |-> stub_valid[s-1]); // R8
        AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            stub_valid[s] |-> (stub_addr[s] > stub_addr[s-1])); // R8
    end
endmodule

// File: tb/tb_stub_correlator.sv
// Bench: directed scenarios for the stub correlator. Each task drives one crossing pattern and
// checks the registered outputs after the edge.
module tb_stub_correlator;
    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [255:0]        lower_map = '0;
    logic [255:0]        upper_map = '0;
    logic [3:0]          win_half = '0;
    logic [4:0]          offset = '0;
    logic                stub_flag, or_flag, overflow;
    logic [2:0]          stub_valid;
    logic [2:0][7:0]     stub_addr;
    logic [2:0][4:0]     stub_bend;

    int n_chk = 0;
    int n_bad = 0;

    stub_correlator dut (
        .clk(clk), .rst_n(rst_n), .lower_map(lower_map), .upper_map(upper_map),
        .win_half(win_half), .offset(offset), .stub_flag(stub_flag), .or_flag(or_flag),
        .stub_valid(stub_valid), .stub_addr(stub_addr), .stub_bend(stub_bend),
        .overflow(overflow)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one crossing at the falling edge, then sample 1 ns after the next rising edge
    task automatic crossing(input logic [255:0] lo, input logic [255:0] up,
                            input int win, input int off);
        @(negedge clk);
        lower_map = lo;
        upper_map = up;
        win_half  = win[3:0];
        offset    = off[4:0];
        @(posedge clk);
        #1;
    endtask

    function automatic logic [255:0] bits2(input int a, input int b);
        logic [255:0] m;
        m = '0;
        if (a >= 0) m[a] = 1'b1;
        if (b >= 0) m[b] = 1'b1;
        return m;
    endfunction

    task automatic chk_stub(input string tag, input int slot, input int addr, input int bnd);
        logic [4:0] eb;
        eb = bnd[4:0];
        chk({tag, " valid"}, int'(stub_valid[slot]), 1);
        chk({tag, " addr"}, int'(stub_addr[slot]), addr);
        chk({tag, " bend"}, int'(stub_bend[slot]), int'(eb));
    endtask

    task automatic t_reset;
        chk("R1 stub_flag", int'(stub_flag), 0);
        chk("R1 or_flag", int'(or_flag), 0);
        chk("R1 valid", int'(stub_valid), 0);
        chk("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_single_latency;
        @(negedge clk);
        lower_map = bits2(40, -1);
        upper_map = bits2(43, -1);
        win_half = 4'd7;
        offset = 5'd0;
        #1;
        chk("R10 before edge", int'(stub_flag), 0);
        @(posedge clk);
        #1;
        chk("R10 after edge", int'(stub_flag), 1);
        chk_stub("R2 R3 single", 0, 40, 3);
        chk("R6 flag", int'(stub_flag), 1);
        chk("R8 one slot", int'(stub_valid), 3'b001);
    endtask

    task automatic t_window_edge;
        crossing(bits2(50, -1), bits2(54, -1), 3, 0);
        chk("R2 outside window", int'(stub_valid), 0);
        chk("R6 no stub", int'(stub_flag), 0);
        chk("R7 or without stub", int'(or_flag), 1);
        crossing(bits2(50, -1), bits2(53, -1), 3, 0);
        chk_stub("R2 window edge", 0, 50, 3);
        crossing('0, '0, 3, 0);
        chk("R7 empty", int'(or_flag), 0);
        crossing('0, bits2(9, -1), 3, 0);
        chk("R7 upper only", int'(or_flag), 1);
    endtask

    task automatic t_offset_zero_win;
        crossing(bits2(100, -1), bits2(96, -1), 0, -4);
        chk_stub("R4 R12 offset exact", 0, 100, 0);
        crossing(bits2(100, -1), bits2(97, -1), 0, -4);
        chk("R12 off by one", int'(stub_valid), 0);
        crossing(bits2(100, -1), bits2(97, -1), 5, -4);
        chk_stub("R4 shifted bend", 0, 100, 1);
    endtask

    task automatic t_negative_bend;
        crossing(bits2(10, -1), bits2(5, -1), 7, 0);
        chk_stub("R3 negative", 0, 10, -5);
    endtask

    task automatic t_nearest;
        crossing(bits2(60, -1), bits2(57, 62), 7, 0);
        chk_stub("R5 nearest", 0, 60, 2);
        crossing(bits2(60, -1), bits2(58, 62), 7, 0);
        chk_stub("R5 tie negative", 0, 60, -2);
    endtask

    task automatic t_multi;
        logic [255:0] m;
        m = bits2(200, 20) | bits2(80, 150);
        crossing(m, m, 0, 0);
        chk_stub("R8 slot0", 0, 20, 0);
        chk_stub("R8 slot1", 1, 80, 0);
        chk_stub("R8 slot2", 2, 150, 0);
        chk("R9 overflow set", int'(overflow), 1);
        m = bits2(200, 20);
        crossing(m, m, 0, 0);
        chk("R8 two valid", int'(stub_valid), 3'b011);
        chk("R8 second addr", int'(stub_addr[1]), 200);
        chk("R9 no overflow", int'(overflow), 0);
        m = bits2(200, 20) | bits2(80, -1);
        crossing(m, m, 0, 0);
        chk("R9 exactly three", int'(overflow), 0);
        chk("R8 three valid", int'(stub_valid), 3'b111);
    endtask

    task automatic t_boundary;
        crossing(bits2(2, -1), bits2(255, -1), 1, -4);
        chk("R11 no wrap low", int'(stub_valid), 0);
        crossing(bits2(253, -1), bits2(0, 255), 2, 3);
        chk_stub("R11 top end", 0, 253, -1);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_single_latency();
        t_window_edge();
        t_offset_zero_win();
        t_negative_bend();
        t_nearest();
        t_multi();
        t_boundary();
        lower_map = bits2(7, -1);
        upper_map = bits2(7, -1);
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule